// File: doc/BRIEF.md
# I2C Bus Condition Generator

This block produces the START, repeated-START and STOP conditions on the two open-drain lines of an I2C bus. Software uses one 8-bit control byte to pick a condition and to route each line. A condition sequencer then walks the lines through the required edges. Each edge is spaced by a programmable half-period count. Byte shifting, acknowledge handling, clock stretching and baud generation belong to neighbouring logic and are not part of this block.

Each line has its own four-way source select:
- the serial shifter's drive,
- the condition sequencer,
- a forced low level,
- release.

A condition request bit clears itself once its condition has fully played out, and the completion flag is then set. Writing zero to a request bit that is pending or running abandons it. The pin outputs are pull-low enables: 1 means the pad drives low, 0 means the line floats high.

Top module: `i2c_cond_gen`

## Requirements
- R1: Synchronous active-high reset clears the whole control byte to 0x00, and the sequencer releases both lines.
- R2: Each line has a 2-bit source select. SCL uses bits 7:6 and SDA uses bits 5:4. The codes are: 00 = follow the shifter's pull input, 01 = follow the sequencer, 10 = pull low, 11 = release (pull 0).
- R3: Control byte layout: bit0 = START request, bit1 = repeated-START request, bit2 = STOP request, bit3 = completion flag, bits 7:4 = the two selects. A write stores the selects and each request bit as written. At most one request bit is ever set.
- R4: A write with two or more of bits 2:0 set leaves all request bits 0, and no condition is produced.
- R5: The flag becomes 1 on the cycle a condition finishes. A write with bit3 = 0 clears the flag, and a write with bit3 = 1 leaves it unchanged. A completion in the same cycle as a clearing write leaves the flag at 1 and the request bit at 0.
- R6: START launches only when both lines are sampled high. SDA is pulled low at launch. SCL is pulled low N cycles later, and the flag is set at that same edge.
- R7: Repeated-START launches only when SCL is sampled low. SDA is released at launch, SCL is released N cycles later, SDA is pulled low after N more cycles, and SCL is pulled low and the flag set after N more (3N in total).
- R8: STOP launches only when SCL is sampled low. SDA is pulled low at launch, SCL is released N cycles later, and SDA is released and the flag set after N more (2N in total).
- R9: A launch also needs both selects at 01 and the flag at 0. Until then the sequencer waits and the request bit stays set.
- R10: Clearing the active request bit by a write stops the sequence at the next edge. The lines hold their levels and the flag stays 0.
- R11: N is the half-period input, and a value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| half_period | input | CNT_W | Half-period count N |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| shf_scl_low | input | 1 | Shifter's SCL pull-low request |
| shf_sda_low | input | 1 | Shifter's SDA pull-low request |
| scl_pull | output | 1 | SCL pad pull-low enable |
| sda_pull | output | 1 | SDA pad pull-low enable |
| ctl_rd | output | 8 | Current control byte including the flag |

## Verification
A software write and the sequencer's own completion can both update the control byte on the same edge. The bench times a write that clears the flag and re-arms the request so that it lands on the finishing edge of a START. It expects the flag set and the request bit cleared. A second run lands a request-clearing write one edge earlier and expects the sequence abandoned with the flag still 0.

// File: rtl/i2c_cg_pkg.sv
package i2c_cg_pkg;

    // line source select codes
    typedef enum logic [1:0] {
        PSEL_SHIFT = 2'b00,
        PSEL_SEQ   = 2'b01,
        PSEL_LOW   = 2'b10,
        PSEL_FREE  = 2'b11
    } psel_e;

    // control byte, MSB first
    typedef struct packed {
        psel_e      scl_sel;
        psel_e      sda_sel;
        logic       done;
        logic [2:0] req;
    } ctl_t;

    localparam int REQ_STA = 0;
    localparam int REQ_RST = 1;
    localparam int REQ_STP = 2;

    localparam int PIN_SCL = 0;
    localparam int PIN_SDA = 1;
    localparam int NPIN    = 2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_STA_HOLD,
        SQ_RS_SDA_UP,
        SQ_RS_SCL_UP,
        SQ_RS_SDA_DN,
        SQ_SP_SDA_DN,
        SQ_SP_SCL_UP
    } sq_state_e;

    function automatic logic multi_hot(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

    // request bit owned by a sequencer state
    function automatic logic [2:0] state_req(input sq_state_e s);
        logic [2:0] r;
        r = '0;
        case (s)
            SQ_STA_HOLD:                              r[REQ_STA] = 1'b1;
            SQ_RS_SDA_UP, SQ_RS_SCL_UP, SQ_RS_SDA_DN: r[REQ_RST] = 1'b1;
            SQ_SP_SDA_DN, SQ_SP_SCL_UP:               r[REQ_STP] = 1'b1;
            default:                                  r = '0;
        endcase
        return r;
    endfunction

    function automatic logic last_phase(input sq_state_e s);
        return (s == SQ_STA_HOLD) || (s == SQ_RS_SDA_DN) || (s == SQ_SP_SCL_UP);
    endfunction

    function automatic logic pin_pull(input psel_e sel, input logic shf, input logic seq);
        logic p;
        case (sel)
            PSEL_SHIFT: p = shf;
            PSEL_SEQ:   p = seq;
            PSEL_LOW:   p = 1'b1;
            default:    p = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/i2c_cg_regs.sv
module i2c_cg_regs
    import i2c_cg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [2:0] fin_mask,
    output ctl_t       ctl
);

    ctl_t nxt;

    always_comb begin
        nxt = ctl;
        if (wr_en) begin
            nxt.scl_sel = psel_e'(wr_data[7:6]);
            nxt.sda_sel = psel_e'(wr_data[5:4]);
            // conflicting requests are discarded
            nxt.req     = multi_hot(wr_data[2:0]) ? 3'b000 : wr_data[2:0];
            if (!wr_data[3]) begin
                nxt.done = 1'b0;
            end
        end
        // completion overrides a same-cycle write
        if (|fin_mask) begin
            nxt.req  = nxt.req & ~fin_mask;
            nxt.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            ctl <= nxt;
        end
    end

endmodule

// File: rtl/i2c_cg_seq.sv
module i2c_cg_seq
    import i2c_cg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [CNT_W-1:0] half_period,
    output logic             seq_scl_low,
    output logic             seq_sda_low,
    output logic [2:0]       fin_mask
);

    sq_state_e        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n, load;
    logic             scl_n, sda_n;
    logic             cnt_zero, aborted, go;
    logic [2:0]       act_req;

    assign load     = (half_period == '0) ? '0 : half_period - 1'b1;
    assign cnt_zero = (cnt == '0);
    assign act_req  = state_req(state);
    assign aborted  = (state != SQ_IDLE) && ((ctl.req & act_req) == 3'b000);
    assign go       = (ctl.scl_sel == PSEL_SEQ) && (ctl.sda_sel == PSEL_SEQ) && !ctl.done;

    always_comb begin
        fin_mask = 3'b000;
        if (!aborted && cnt_zero && last_phase(state)) begin
            fin_mask = act_req;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt_zero ? cnt : cnt - 1'b1;
        scl_n   = seq_scl_low;
        sda_n   = seq_sda_low;
        if (state == SQ_IDLE) begin
            if (go) begin
                if (ctl.req[REQ_STA] && scl_in && sda_in) begin
                    sda_n   = 1'b1;
                    scl_n   = 1'b0;
                    state_n = SQ_STA_HOLD;
                    cnt_n   = load;
                end else if (ctl.req[REQ_RST] && !scl_in) begin
                    sda_n   = 1'b0;
                    state_n = SQ_RS_SDA_UP;
                    cnt_n   = load;
                end else if (ctl.req[REQ_STP] && !scl_in) begin
                    sda_n   = 1'b1;
                    state_n = SQ_SP_SDA_DN;
                    cnt_n   = load;
                end
            end
        end else if (aborted) begin
            state_n = SQ_IDLE;
        end else if (cnt_zero) begin
            case (state)
                SQ_STA_HOLD: begin
                    scl_n   = 1'b1;
                    state_n = SQ_IDLE;
                end
                SQ_RS_SDA_UP: begin
                    scl_n   = 1'b0;
                    state_n = SQ_RS_SCL_UP;
                    cnt_n   = load;
                end
                SQ_RS_SCL_UP: begin
                    sda_n   = 1'b1;
                    state_n = SQ_RS_SDA_DN;
                    cnt_n   = load;
                end
                SQ_RS_SDA_DN: begin
                    scl_n   = 1'b1;
                    state_n = SQ_IDLE;
                end
                SQ_SP_SDA_DN: begin
                    scl_n   = 1'b0;
                    state_n = SQ_SP_SCL_UP;
                    cnt_n   = load;
                end
                SQ_SP_SCL_UP: begin
                    sda_n   = 1'b0;
                    state_n = SQ_IDLE;
                end
                default: state_n = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_IDLE;
            cnt         <= '0;
            seq_scl_low <= 1'b0;
            seq_sda_low <= 1'b0;
        end else begin
            state       <= state_n;
            cnt         <= cnt_n;
            seq_scl_low <= scl_n;
            seq_sda_low <= sda_n;
        end
    end

endmodule

// File: rtl/i2c_cg_pinmux.sv
module i2c_cg_pinmux
    import i2c_cg_pkg::*;
(
    input  psel_e sel,
    input  logic  shf_low,
    input  logic  seq_low,
    output logic  pull
);

    assign pull = pin_pull(sel, shf_low, seq_low);

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2c_cg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [CNT_W-1:0] half_period,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             shf_scl_low,
    input  logic             shf_sda_low,
    output logic             scl_pull,
    output logic             sda_pull,
    output logic [7:0]       ctl_rd
);

    ctl_t       ctl;
    logic [2:0] fin_mask;
    logic       seq_scl_low, seq_sda_low;

    psel_e sel_a  [NPIN];
    logic  shf_a  [NPIN];
    logic  seq_a  [NPIN];
    logic  pull_a [NPIN];

    i2c_cg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .fin_mask (fin_mask),
        .ctl      (ctl)
    );

    i2c_cg_seq #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .half_period (half_period),
        .seq_scl_low (seq_scl_low),
        .seq_sda_low (seq_sda_low),
        .fin_mask    (fin_mask)
    );

    assign sel_a[PIN_SCL] = ctl.scl_sel;
    assign sel_a[PIN_SDA] = ctl.sda_sel;
    assign shf_a[PIN_SCL] = shf_scl_low;
    assign shf_a[PIN_SDA] = shf_sda_low;
    assign seq_a[PIN_SCL] = seq_scl_low;
    assign seq_a[PIN_SDA] = seq_sda_low;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        i2c_cg_pinmux u_mux (
            .sel     (sel_a[g]),
            .shf_low (shf_a[g]),
            .seq_low (seq_a[g]),
            .pull    (pull_a[g])
        );
    end

    assign scl_pull = pull_a[PIN_SCL];
    assign sda_pull = pull_a[PIN_SDA];
    assign ctl_rd   = ctl;

endmodule

// File: rtl/i2c_cond_gen_chk.sv
module i2c_cond_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       scl_in,
    input logic       sda_in,
    input logic       sda_pull,
    input logic [7:0] ctl_rd
);

    // R4
    multi_req_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ($countones(wr_data[2:0]) > 1)) |=> (ctl_rd[2:0] == 3'b000));

    // R3
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(ctl_rd[2:0]) <= 1);

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd[3] && !(wr_en && !wr_data[3])) |=> ctl_rd[3]);

    // R5
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_rd[3]) |-> $past(|ctl_rd[2:0]));

    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && (($past(ctl_rd[2:0]) & ~ctl_rd[2:0]) != 3'b000)) |-> ctl_rd[3]);

    // R6
    sta_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd[0] && (ctl_rd[7:4] == 4'b0101) && $stable(ctl_rd[7:4]) && $rose(sda_pull))
        |-> ($past(scl_in) && $past(sda_in)));

    // R8
    stp_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd[2] && (ctl_rd[7:4] == 4'b0101) && $stable(ctl_rd[7:4]) && $rose(sda_pull))
        |-> !$past(scl_in));

endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_pull (sda_pull),
    .ctl_rd   (ctl_rd)
);

// File: tb/sim_i2c_cond_gen.sv
module sim_i2c_cond_gen;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = 8'h00;
    logic [CNT_W-1:0] half_period = '0;
    logic             shf_scl_low = 1'b0;
    logic             shf_sda_low = 1'b0;
    logic             ext_scl_low = 1'b0;
    logic             ext_sda_low = 1'b0;
    logic             scl_in, sda_in, scl_pull, sda_pull;
    logic [7:0]       ctl_rd;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // open-drain bus
    assign scl_in = !(scl_pull || ext_scl_low);
    assign sda_in = !(sda_pull || ext_sda_low);

    i2c_cond_gen #(.CNT_W(CNT_W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .half_period (half_period),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .shf_scl_low (shf_scl_low),
        .shf_sda_low (shf_sda_low),
        .scl_pull    (scl_pull),
        .sda_pull    (sda_pull),
        .ctl_rd      (ctl_rd)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wr_now(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic pull_of(input logic [1:0] sel, input logic shf);
        case (sel)
            2'b00:   return shf;
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // which: 0 START (R6), 1 repeated-START (R7), 2 STOP (R8)
    task automatic run_cond(input int which, input int n);
        int   ne, phases;
        logic es, ec, ef;
        ne = (n == 0) ? 1 : n;
        phases = (which == 0) ? 1 : ((which == 1) ? 3 : 2);
        half_period = CNT_W'(n);
        wr(8'h50 | 8'(1 << which));
        chk((which == 0) ? "R6 pre" : "R7/R8 pre", ctl_rd, 8'h50 | 8'(1 << which));
        chk("R6 R7 R8 pre sda", {7'b0, sda_pull}, (which == 0) ? 8'h00 : 8'h01);
        for (int c = 1; c <= phases * ne + 2; c++) begin
            int t;
            @(negedge clk);
            t = c - 1;
            if (which == 0) begin
                es = 1'b1; ec = (t >= ne); ef = (t >= ne);
            end else if (which == 1) begin
                es = (t >= 2 * ne); ec = (t < ne) || (t >= 3 * ne); ef = (t >= 3 * ne);
            end else begin
                es = (t < 2 * ne); ec = (t < ne); ef = (t >= 2 * ne);
            end
            if (n == 0) begin
                chk("R11 sda", {7'b0, sda_pull}, {7'b0, es});
            end
            chk((which == 0) ? "R6 sda" : ((which == 1) ? "R7 sda" : "R8 sda"),
                {7'b0, sda_pull}, {7'b0, es});
            chk((which == 0) ? "R6 scl" : ((which == 1) ? "R7 scl" : "R8 scl"),
                {7'b0, scl_pull}, {7'b0, ec});
            chk("R5 flag", ctl_rd, ef ? 8'h58 : (8'h50 | 8'(1 << which)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 ctl", ctl_rd, 8'h00);
        chk("R1 scl", {7'b0, scl_pull}, 8'h00);
        chk("R1 sda", {7'b0, sda_pull}, 8'h00);

        // R2 / R3: every select pair against every shifter level
        for (int s = 0; s < 16; s++) begin
            wr({s[3:0], 4'b0000});
            chk("R3 sel store", ctl_rd, {s[3:0], 4'b0000});
            for (int h = 0; h < 4; h++) begin
                shf_scl_low = h[1];
                shf_sda_low = h[0];
                #1;
                chk("R2 scl", {7'b0, scl_pull}, {7'b0, pull_of(s[3:2], h[1])});
                chk("R2 sda", {7'b0, sda_pull}, {7'b0, pull_of(s[1:0], h[0])});
            end
        end
        shf_scl_low = 1'b0;
        shf_sda_low = 1'b0;

        // R4: conflicting requests
        for (int d = 3; d < 8; d++) begin
            if (d != 4) begin
                wr(8'h50 | 8'(d));
                chk("R4 ctl", ctl_rd, 8'h50);
                repeat (2) @(negedge clk);
                chk("R4 sda", {7'b0, sda_pull}, 8'h00);
                chk("R4 scl", {7'b0, scl_pull}, 8'h00);
            end
        end

        wr(8'h58);
        chk("R5 write one idle", ctl_rd, 8'h50);

        // R6 R7 R8 R11 sweeps
        for (int n = 0; n < 5; n++) begin
            run_cond(0, n);
            run_cond(1, n);
            run_cond(2, n);
        end

        // R5 / R9: flag blocks launch
        wr(8'h58);
        chk("R5 write one keeps", ctl_rd, 8'h58);
        wr(8'h59);
        repeat (4) @(negedge clk);
        chk("R9 flag blocks", ctl_rd, 8'h59);
        chk("R9 flag blocks sda", {7'b0, sda_pull}, 8'h00);
        wr(8'h50);
        chk("R5 clear", ctl_rd, 8'h50);

        // R9: selects not both sequencer
        wr(8'h11);
        repeat (4) @(negedge clk);
        chk("R9 sel blocks", ctl_rd, 8'h11);
        chk("R9 sel blocks scl", {7'b0, scl_pull}, 8'h00);
        chk("R9 sel blocks sda", {7'b0, sda_pull}, 8'h00);
        wr(8'h50);

        // R6: waits for SDA high
        half_period = 2;
        ext_sda_low = 1'b1;
        wr(8'h51);
        repeat (4) @(negedge clk);
        chk("R6 wait ctl", ctl_rd, 8'h51);
        chk("R6 wait sda", {7'b0, sda_pull}, 8'h00);
        ext_sda_low = 1'b0;
        @(negedge clk);
        chk("R6 launch sda", {7'b0, sda_pull}, 8'h01);
        chk("R6 launch scl", {7'b0, scl_pull}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R6 done", ctl_rd, 8'h58);
        chk("R6 done scl", {7'b0, scl_pull}, 8'h01);
        wr(8'h54);
        repeat (6) @(negedge clk);
        chk("R8 done", ctl_rd, 8'h58);
        chk("R8 released", {6'b0, scl_pull, sda_pull}, 8'h00);

        // R7: waits for SCL low; R10 abort while waiting
        wr(8'h52);
        repeat (4) @(negedge clk);
        chk("R7 wait ctl", ctl_rd, 8'h52);
        chk("R7 wait pins", {6'b0, scl_pull, sda_pull}, 8'h00);
        wr(8'h50);
        repeat (2) @(negedge clk);
        chk("R10 idle abort", ctl_rd, 8'h50);
        chk("R10 idle abort pins", {6'b0, scl_pull, sda_pull}, 8'h00);

        // R5: completion and clearing write on the same edge
        half_period = 3;
        wr(8'h51);
        repeat (3) @(negedge clk);
        wr_now(8'h51);
        chk("R5 same cycle", ctl_rd, 8'h58);
        chk("R5 same cycle scl", {7'b0, scl_pull}, 8'h01);
        wr(8'h54);
        repeat (7) @(negedge clk);
        chk("R8 restore", ctl_rd, 8'h58);
        chk("R8 restore pins", {6'b0, scl_pull, sda_pull}, 8'h00);

        // R10: abort one edge before completion
        wr(8'h51);
        repeat (2) @(negedge clk);
        chk("R10 running scl", {7'b0, scl_pull}, 8'h00);
        wr_now(8'h50);
        repeat (4) @(negedge clk);
        chk("R10 abort ctl", ctl_rd, 8'h50);
        chk("R10 abort scl", {7'b0, scl_pull}, 8'h00);
        chk("R10 abort sda", {7'b0, sda_pull}, 8'h01);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule